// File: doc/BRIEF.md
# Multi-core local interrupt controller

This block collects the interrupt sources that belong to a four-core cluster and turns them into one IRQ line and one FIQ line per core. Sources are four timer inputs per core, sixteen software mailboxes (four owned by each core), one shared external interrupt that can be steered to any core, and one performance-monitor input per core. Software configures the block and reads its state through a simple register port. A write takes effect in the cycle it is presented, and read data appears on the cycle after the read strobe.

Each mailbox is a 32-bit word. One address ORs data into it and a second address clears the bits that are set in the data. The mailbox raises a level request for as long as it holds a nonzero value, which makes it suitable for inter-processor signalling. Each source has an IRQ enable and a FIQ enable. FIQ always wins: a source with both enables set appears only on the FIQ line. The pending words show which sources are active on each line of each core.

Top module: `core_irq_hub`

## Requirements
- R1: After reset all mailboxes, enables and routing fields are zero, `irq_o` and `fiq_o` are low, and `bus_rdata_o` is zero.
- R2: A write to address 0x80 + 0x10·c + 4·m ORs the write data into mailbox m of core c. A read of that address returns the mailbox contents.
- R3: A write to address 0xC0 + 0x10·c + 4·m clears every bit of mailbox m of core c that is 1 in the write data. A read of that address also returns the mailbox contents.
- R4: Mailbox m of core c requests an interrupt at pending bit 4+m for as long as it is nonzero. The request is gated by the mailbox control register of core c at 0x50 + 4·c, where bit m is the IRQ enable and bit 4+m is the FIQ enable.
- R5: The timer control register of core c is at 0x40 + 4·c, with bit t as the IRQ enable and bit 4+t as the FIQ enable of timer input t. Timer input t of core c is port bit `tmr_irq_i[4·c+t]` and shows at pending bit t.
- R6: A source whose FIQ and IRQ enables are both set is delivered on FIQ only, and its IRQ pending bit stays 0.
- R7: The routing register at 0x0C has bits [1:0] naming the core that gets the shared external input as IRQ and bits [3:2] naming the core that gets it as FIQ. When both fields name the same core, only FIQ is raised. The source shows at pending bit 8.
- R8: Writing 0x10 sets, and writing 0x14 clears, the performance-monitor enables selected by the data. Bits [3:0] are the per-core IRQ enables and bits [7:4] are the per-core FIQ enables. Both addresses read back the 8-bit enable field. Input `pmu_irq_i[c]` shows at pending bit 9 of core c.
- R9: The IRQ-pending word of core c reads at 0x60 + 4·c and the FIQ-pending word at 0x70 + 4·c. Writes to these addresses are ignored.
- R10: `irq_o[c]` is the OR of the IRQ-pending word of core c, and `fiq_o[c]` is the OR of its FIQ-pending word. Both are registered, so they change on the first clock edge after the cause.
- R11: Reads of unmapped addresses return zero, and writes to them change nothing.
- R12: `bus_rdata_o` updates only on a cycle with `bus_rd_i` high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| tmr_irq_i | input | 16 | Timer requests, bit 4·c+t is timer t of core c |
| gpu_irq_i | input | 1 | Shared external interrupt request |
| pmu_irq_i | input | 4 | Performance-monitor request per core |
| irq_o | output | 4 | IRQ line per core |
| fiq_o | output | 4 | FIQ line per core |

## Verification
The embedded assertions check, on every cycle, that set and clear writes leave the selected mailbox with the written bits set or cleared. They also check that the read port holds its value when idle, that any active pending bit drives the output one edge later, and that an enabled FIQ mailbox or routed external FIQ reaches its core. They further check that a configuration in which every IRQ enable is paired with its FIQ enable never raises IRQ. The bench scenarios are needed for the exact address map, the pending-word bit layout, the same-core routing collision, the set/clear semantics of the performance-monitor enables, and the silence of unmapped addresses and read-only words. Only the scenarios can show that a level request persists until it is cleared.

// File: rtl/core_irq_pkg.sv
`timescale 1ns/1ps
package core_irq_pkg;
    localparam int NCORE  = 4;
    localparam int NSRC   = 4;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int CORE_W = $clog2(NCORE);
    localparam int CTL_W  = 2 * NSRC;
    localparam int PEND_W = 2 * NSRC + 2;
    localparam int PB_GPU = 2 * NSRC;
    localparam int PB_PMU = 2 * NSRC + 1;

    localparam int A_ROUTE   = 'h0C;
    localparam int A_PMU_SET = 'h10;
    localparam int A_PMU_CLR = 'h14;
    localparam int A_TMR     = 'h40;
    localparam int A_MBXC    = 'h50;
    localparam int A_IPEND   = 'h60;
    localparam int A_FPEND   = 'h70;
    localparam int A_MSET    = 'h80;
    localparam int A_MCLR    = 'hC0;
    localparam int CORE_STEP = 'h10;
    localparam int WORD_STEP = 4;

    typedef struct packed {
        logic [NCORE-1:0][NSRC-1:0][DW-1:0] mbox;
        logic [NCORE-1:0][CTL_W-1:0]        tmr_ctl;
        logic [NCORE-1:0][CTL_W-1:0]        mbx_ctl;
        logic [2*CORE_W-1:0]                route;
        logic [2*NCORE-1:0]                 pmu_en;
        logic [DW-1:0]                      rdata;
    } regs_t;

    typedef struct packed {
        logic irq;
        logic fiq;
    } lines_t;

    function automatic logic [AW-1:0] core_addr(input int base, input int c);
        return AW'(base + WORD_STEP * c);
    endfunction

    function automatic logic [AW-1:0] mbox_addr(input int base, input int c, input int m);
        return AW'(base + CORE_STEP * c + WORD_STEP * m);
    endfunction
endpackage

// File: rtl/cih_regs.sv
`timescale 1ns/1ps
module cih_regs
    import core_irq_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              rd_en,
    input  logic [AW-1:0]                     addr,
    input  logic [DW-1:0]                     wdata,
    input  logic [NCORE-1:0][PEND_W-1:0]      irq_pend,
    input  logic [NCORE-1:0][PEND_W-1:0]      fiq_pend,
    output logic [DW-1:0]                     rdata,
    output logic [NCORE-1:0][NSRC-1:0]        mbx_nz,
    output logic [NCORE-1:0][CTL_W-1:0]       tmr_ctl,
    output logic [NCORE-1:0][CTL_W-1:0]       mbx_ctl,
    output logic [2*CORE_W-1:0]               route,
    output logic [2*NCORE-1:0]                pmu_en
);
    regs_t regs_d, regs_q;
    logic [DW-1:0] rd_word_d;

    always_comb begin
        regs_d    = regs_q;
        rd_word_d = '0;

        if (wr_en) begin
            for (int c = 0; c < NCORE; c++) begin
                if (addr == core_addr(A_TMR, c))
                    regs_d.tmr_ctl[c] = wdata[CTL_W-1:0];
                if (addr == core_addr(A_MBXC, c))
                    regs_d.mbx_ctl[c] = wdata[CTL_W-1:0];
                for (int m = 0; m < NSRC; m++) begin
                    if (addr == mbox_addr(A_MSET, c, m))
                        regs_d.mbox[c][m] = regs_q.mbox[c][m] | wdata;
                    if (addr == mbox_addr(A_MCLR, c, m))
                        regs_d.mbox[c][m] = regs_q.mbox[c][m] & ~wdata;
                end
            end
            if (addr == AW'(A_ROUTE))
                regs_d.route = wdata[2*CORE_W-1:0];
            if (addr == AW'(A_PMU_SET))
                regs_d.pmu_en = regs_q.pmu_en | wdata[2*NCORE-1:0];
            if (addr == AW'(A_PMU_CLR))
                regs_d.pmu_en = regs_q.pmu_en & ~wdata[2*NCORE-1:0];
        end

        for (int c = 0; c < NCORE; c++) begin
            if (addr == core_addr(A_TMR, c))   rd_word_d = DW'(regs_q.tmr_ctl[c]);
            if (addr == core_addr(A_MBXC, c))  rd_word_d = DW'(regs_q.mbx_ctl[c]);
            if (addr == core_addr(A_IPEND, c)) rd_word_d = DW'(irq_pend[c]);
            if (addr == core_addr(A_FPEND, c)) rd_word_d = DW'(fiq_pend[c]);
            for (int m = 0; m < NSRC; m++) begin
                if (addr == mbox_addr(A_MSET, c, m) || addr == mbox_addr(A_MCLR, c, m))
                    rd_word_d = regs_q.mbox[c][m];
            end
        end
        if (addr == AW'(A_ROUTE))
            rd_word_d = DW'(regs_q.route);
        if (addr == AW'(A_PMU_SET) || addr == AW'(A_PMU_CLR))
            rd_word_d = DW'(regs_q.pmu_en);

        if (rd_en)
            regs_d.rdata = rd_word_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        for (int c = 0; c < NCORE; c++)
            for (int m = 0; m < NSRC; m++)
                mbx_nz[c][m] = |regs_q.mbox[c][m];
    end

    assign rdata   = regs_q.rdata;
    assign tmr_ctl = regs_q.tmr_ctl;
    assign mbx_ctl = regs_q.mbx_ctl;
    assign route   = regs_q.route;
    assign pmu_en  = regs_q.pmu_en;

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    for (genvar gc = 0; gc < NCORE; gc++) begin : g_mbx_chk
        for (genvar gm = 0; gm < NSRC; gm++) begin : g_slot
            // R2
            mbox_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == mbox_addr(A_MSET, gc, gm))
                |=> ((regs_q.mbox[gc][gm] & $past(wdata)) == $past(wdata)));
            // R3
            mbox_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && addr == mbox_addr(A_MCLR, gc, gm))
                |=> ((regs_q.mbox[gc][gm] & $past(wdata)) == '0));
        end
    end
endmodule

// File: rtl/cih_core_merge.sv
`timescale 1ns/1ps
module cih_core_merge
    import core_irq_pkg::*;
#(
    parameter int CORE_ID = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        tmr_i,
    input  logic [NSRC-1:0]        mbx_nz,
    input  logic [CTL_W-1:0]       tmr_ctl,
    input  logic [CTL_W-1:0]       mbx_ctl,
    input  logic                   gpu_i,
    input  logic [2*CORE_W-1:0]    route,
    input  logic                   pmu_i,
    input  logic                   pmu_irq_en,
    input  logic                   pmu_fiq_en,
    output logic [PEND_W-1:0]      irq_pend,
    output logic [PEND_W-1:0]      fiq_pend,
    output logic                   irq_o,
    output logic                   fiq_o
);
    localparam logic [CORE_W-1:0] ME = CORE_W'(CORE_ID);

    lines_t lines_d, lines_q;
    logic   gpu_fiq_here, gpu_irq_here;

    always_comb begin
        gpu_fiq_here = route[2*CORE_W-1:CORE_W] == ME;
        gpu_irq_here = (route[CORE_W-1:0] == ME) && !gpu_fiq_here;

        fiq_pend[NSRC-1:0]      = tmr_i & tmr_ctl[CTL_W-1:NSRC];
        irq_pend[NSRC-1:0]      = tmr_i & tmr_ctl[NSRC-1:0] & ~tmr_ctl[CTL_W-1:NSRC];
        fiq_pend[2*NSRC-1:NSRC] = mbx_nz & mbx_ctl[CTL_W-1:NSRC];
        irq_pend[2*NSRC-1:NSRC] = mbx_nz & mbx_ctl[NSRC-1:0] & ~mbx_ctl[CTL_W-1:NSRC];
        fiq_pend[PB_GPU]        = gpu_i && gpu_fiq_here;
        irq_pend[PB_GPU]        = gpu_i && gpu_irq_here;
        fiq_pend[PB_PMU]        = pmu_i && pmu_fiq_en;
        irq_pend[PB_PMU]        = pmu_i && pmu_irq_en && !pmu_fiq_en;

        lines_d.irq = |irq_pend;
        lines_d.fiq = |fiq_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

    assign irq_o = lines_q.irq;
    assign fiq_o = lines_q.fiq;

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pend) |=> irq_o);
    // R10
    fiq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|fiq_pend) |=> !fiq_o);
    // R4
    mbox_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mbx_nz & mbx_ctl[CTL_W-1:NSRC])) |=> fiq_o);
    // R7
    gpu_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gpu_i && route[2*CORE_W-1:CORE_W] == ME) |=> fiq_o);
    // R6
    fiq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ctl[NSRC-1:0] == tmr_ctl[CTL_W-1:NSRC] &&
         mbx_ctl[NSRC-1:0] == mbx_ctl[CTL_W-1:NSRC] && !gpu_i && !pmu_i) |=> !irq_o);
endmodule

// File: rtl/core_irq_hub.sv
`timescale 1ns/1ps
module core_irq_hub
    import core_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic [AW-1:0]         bus_addr_i,
    input  logic [DW-1:0]         bus_wdata_i,
    output logic [DW-1:0]         bus_rdata_o,
    input  logic [NCORE*NSRC-1:0] tmr_irq_i,
    input  logic                  gpu_irq_i,
    input  logic [NCORE-1:0]      pmu_irq_i,
    output logic [NCORE-1:0]      irq_o,
    output logic [NCORE-1:0]      fiq_o
);
    logic [NCORE-1:0][PEND_W-1:0] irq_pend, fiq_pend;
    logic [NCORE-1:0][NSRC-1:0]   mbx_nz;
    logic [NCORE-1:0][CTL_W-1:0]  tmr_ctl, mbx_ctl;
    logic [2*CORE_W-1:0]          route;
    logic [2*NCORE-1:0]           pmu_en;

    cih_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_i),
        .rd_en    (bus_rd_i),
        .addr     (bus_addr_i),
        .wdata    (bus_wdata_i),
        .irq_pend (irq_pend),
        .fiq_pend (fiq_pend),
        .rdata    (bus_rdata_o),
        .mbx_nz   (mbx_nz),
        .tmr_ctl  (tmr_ctl),
        .mbx_ctl  (mbx_ctl),
        .route    (route),
        .pmu_en   (pmu_en)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        cih_core_merge #(.CORE_ID(c)) u_merge (
            .clk        (clk),
            .rst_n      (rst_n),
            .tmr_i      (tmr_irq_i[c*NSRC +: NSRC]),
            .mbx_nz     (mbx_nz[c]),
            .tmr_ctl    (tmr_ctl[c]),
            .mbx_ctl    (mbx_ctl[c]),
            .gpu_i      (gpu_irq_i),
            .route      (route),
            .pmu_i      (pmu_irq_i[c]),
            .pmu_irq_en (pmu_en[c]),
            .pmu_fiq_en (pmu_en[NCORE+c]),
            .irq_pend   (irq_pend[c]),
            .fiq_pend   (fiq_pend[c]),
            .irq_o      (irq_o[c]),
            .fiq_o      (fiq_o[c])
        );
    end
endmodule

// File: tb/core_irq_hub_tb_top.sv
`timescale 1ns/1ps
module core_irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [15:0] tmr;
    logic        gpu;
    logic [3:0]  pmu, irq, fiq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    logic rd_seen = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    core_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .tmr_irq_i(tmr), .gpu_irq_i(gpu), .pmu_irq_i(pmu),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", r, act, exp);
        end
    endtask

    // monitor: pops expected read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read without expectation, actual=0x%08h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(r);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic [3:0] ei, input logic [3:0] ef, input string r);
        check({r, " irq_o"}, 32'(irq), 32'(ei));
        check({r, " fiq_o"}, 32'(fiq), 32'(ef));
    endtask

    initial begin
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        tmr = '0; gpu = 0; pmu = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        lines(4'h0, 4'h0, "R1");
        check("R1 rdata", bus_rdata, 32'h0);
        rd(8'h98, 32'h0, "R1 mailbox zero");
        rd(8'h54, 32'h0, "R1 control zero");

        // R2 set ORs into core1 mailbox2
        wr(8'h98, 32'h0000_00F0);
        wr(8'h98, 32'h0F00_0001);
        rd(8'h98, 32'h0F00_00F1, "R2 set accumulates");
        rd(8'hD8, 32'h0F00_00F1, "R3 clear address reads contents");
        // R3 clear
        wr(8'hD8, 32'h0F00_0001);
        rd(8'h98, 32'h0000_00F0, "R3 clear bits");

        // R4 level request from mailbox, IRQ enable
        wr(8'h54, 32'h04);
        tick(1);
        lines(4'b0010, 4'b0000, "R4 mailbox irq");
        tick(3);
        lines(4'b0010, 4'b0000, "R4 level held");
        rd(8'h64, 32'h40, "R9 irq pending mailbox bit");
        wr(8'hD8, 32'hF0);
        tick(1);
        lines(4'b0000, 4'b0000, "R4 cleared");

        // R6 FIQ override on mailbox
        wr(8'h98, 32'h1);
        wr(8'h54, 32'h44);
        tick(1);
        lines(4'b0000, 4'b0010, "R6 mailbox fiq only");
        rd(8'h64, 32'h0, "R6 irq pending empty");
        rd(8'h74, 32'h40, "R9 fiq pending mailbox bit");
        wr(8'hD8, 32'h1);
        wr(8'h54, 32'h0);
        tick(1);
        lines(4'b0000, 4'b0000, "R4 idle");

        // R5 timers on core3: t0 IRQ, t1 FIQ
        wr(8'h4C, 32'h21);
        tmr = 16'h1000;
        #1;
        lines(4'b0000, 4'b0000, "R10 not combinational");
        @(negedge clk);
        lines(4'b1000, 4'b0000, "R10 one edge later");
        tmr = 16'h3000;
        tick(1);
        lines(4'b1000, 4'b1000, "R5 timer irq and fiq");
        rd(8'h6C, 32'h1, "R5 irq pending timer0");
        rd(8'h7C, 32'h2, "R5 fiq pending timer1");
        tmr = 16'h0;
        tick(1);
        lines(4'b0000, 4'b0000, "R10 drop");
        rd(8'h4C, 32'h21, "R5 control readback");

        // R7 routing to different cores, then same core
        wr(8'h0C, 32'h9);
        gpu = 1'b1;
        tick(1);
        lines(4'b0010, 4'b0100, "R7 split route");
        rd(8'h64, 32'h100, "R7 irq pending bit8");
        rd(8'h78, 32'h100, "R7 fiq pending bit8");
        wr(8'h0C, 32'hA);
        tick(1);
        lines(4'b0000, 4'b0100, "R7 same core fiq only");
        rd(8'h68, 32'h0, "R7 no irq pending on collision");
        gpu = 1'b0;
        tick(1);
        lines(4'b0000, 4'b0000, "R7 idle");

        // R8 performance monitor enables
        wr(8'h10, 32'h81);
        rd(8'h14, 32'h81, "R8 set readback");
        pmu = 4'hF;
        tick(1);
        lines(4'b0001, 4'b1000, "R8 irq core0 fiq core3");
        rd(8'h7C, 32'h200, "R8 fiq pending bit9");
        wr(8'h10, 32'h08);
        tick(1);
        lines(4'b0001, 4'b1000, "R6 pmu fiq wins");
        rd(8'h10, 32'h89, "R8 set accumulates");
        wr(8'h14, 32'h01);
        tick(1);
        lines(4'b0000, 4'b1000, "R8 clear core0");
        rd(8'h10, 32'h88, "R8 clear readback");
        pmu = 4'h0;
        tick(1);

        // R11 unmapped, R9 read-only pending
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R11 unmapped read");
        wr(8'h60, 32'hFFFF);
        rd(8'h60, 32'h0, "R9 pending write ignored");
        wr(8'h3C, 32'h5);
        rd(8'h0C, 32'hA, "R11 route untouched");
        rd(8'h20, 32'h0, "R11 unmapped read 0x20");
        tick(1);
        lines(4'b0000, 4'b0000, "R11 no effect on lines");

        // R12 read data holds; width of control field
        wr(8'h54, 32'hFFFF_FF12);
        rd(8'h54, 32'h12, "R4 control width");
        tick(2);
        check("R12 rdata held", bus_rdata, 32'h12);
        wr(8'h94, 32'h8000_0000);
        wr(8'h8C, 32'h1);
        tick(1);
        lines(4'b0010, 4'b0000, "R2 core1 mbox1 irq only");
        rd(8'hD4, 32'h8000_0000, "R2 high bit set");

        tick(2);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule